// File: doc/BRIEF.md
# Serial Register Slave with Auto-Incrementing Address

This block is a serial-bus slave that lets a host read and write a bank of twelve 8-bit configuration registers over a chip select, a serial clock and a data-in line. It returns read data on a data-out line that has its own enable, so the pad can be tri-stated. Every access is a burst framed by chip select. The first byte of a burst is a command that gives the starting register and the direction. Each data byte after it goes to, or comes from, the next register in turn.

The current register contents are also driven on a flat parallel bus for use by the logic they configure. The serial inputs are brought into the block's own clock domain through synchronizers and edge detectors. The serial clock must therefore run several times slower than the system clock.

Top module: `spi_regbank_slave`

## Requirements
- R1: After reset, all twelve registers read 0x00 and the data-out enable is low.
- R2: The command byte is sent MSB first. Its upper seven bits are the register address and its least significant bit is the direction: 0 selects a write, 1 selects a read. A single write of 16 serial clocks stores the following data byte, sent MSB first, into the addressed register.
- R3: In a write burst, each further complete data byte goes to the register one above the previous one.
- R4: When the address pointer advances from 0x0B, or from any address above 0x0B, it becomes 0x00. This applies in both write and read bursts.
- R5: In a read burst, data-out carries the addressed register first, MSB first, and then the registers that follow it. Each bit is valid before the serial clock rising edge that samples it, and the enable is high throughout.
- R6: After the command byte of a read burst, data-in is ignored until chip select is released, and no register changes.
- R7: The data-out enable is low during write bursts, during the command byte, and whenever chip select is high.
- R8: Raising chip select in the middle of a byte discards that byte. The next burst starts with a fresh command byte.
- R9: Writes to addresses above 0x0B are dropped, and reads from them return 0x00.
- R10: The parallel bus carries register n in bits [8n+7:8n] and reflects every completed write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data in, sampled on the rising serial clock edge |
| sdo | output | 1 | Serial data out, changes after the falling serial clock edge |
| sdo_en | output | 1 | Drive enable for sdo; low means high impedance |
| regs_flat | output | 96 | All registers side by side, register 0 in the low byte |

## Verification
The bench runs write and read bursts that start at 0x09 and cross the 0x0B boundary. A pointer that failed to wrap would write past the bank, and reads would show the wrong order. It drives busy data on data-in during a read burst; a slave that kept decoding it would corrupt registers. It releases chip select after half a byte and then runs a clean burst; a bit counter left uncleared would shift every later byte and misplace the data. It accesses addresses above 0x0B, where an aliased decode would overwrite a real register. It also watches the enable on every bit, which catches a data-out that drives the shared line outside a read.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2
  } phase_e;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sel,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sdi_s
);
  logic [STAGES-1:0] cs_q, cs_d;
  logic [STAGES-1:0] ck_q, ck_d;
  logic [STAGES-1:0] di_q, di_d;
  logic              ck_prev_q, ck_prev_d;

  always_comb begin
    cs_d      = {cs_q[STAGES-2:0], cs_n};
    ck_d      = {ck_q[STAGES-2:0], sclk};
    di_d      = {di_q[STAGES-2:0], sdi};
    ck_prev_d = ck_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q      <= '1;
      ck_q      <= '0;
      di_q      <= '0;
      ck_prev_q <= 1'b0;
    end else begin
      cs_q      <= cs_d;
      ck_q      <= ck_d;
      di_q      <= di_d;
      ck_prev_q <= ck_prev_d;
    end
  end

  assign sel       = ~cs_q[STAGES-1];
  assign sdi_s     = di_q[STAGES-1];
  assign sclk_rise = ck_q[STAGES-1] & ~ck_prev_q;
  assign sclk_fall = ~ck_q[STAGES-1] & ck_prev_q;
endmodule

// File: rtl/spi_rb_ctrl.sv
module spi_rb_ctrl
  import spi_rb_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 12,
  localparam int ADDR_W  = DATA_W - 1,
  localparam int CNT_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              byte_done,
  output phase_e            phase,
  output logic              sdo,
  output logic              sdo_en
);
  localparam int LAST = NUM_REGS - 1;

  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-2:0] shf_q, shf_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              sdo_q, sdo_d;
  logic              oe_q, oe_d;
  logic [DATA_W-1:0] byte_in;
  logic [ADDR_W-1:0] addr_nxt;
  logic [CNT_W-1:0]  bit_idx;
  logic              last_bit;

  always_comb begin
    byte_in   = {shf_q, sdi_s};
    last_bit  = sclk_rise && (cnt_q == CNT_W'(DATA_W - 1));
    byte_done = sel && last_bit;
    addr_nxt  = (addr_q >= ADDR_W'(LAST)) ? '0 : addr_q + 1'b1;
    bit_idx   = CNT_W'(DATA_W - 1) - cnt_q;
    rd_addr   = (byte_done && phase_q == PH_CMD) ? byte_in[DATA_W-1:1] : addr_q;

    phase_d = phase_q;
    cnt_d   = cnt_q;
    shf_d   = shf_q;
    addr_d  = addr_q;
    sdo_d   = sdo_q;
    oe_d    = oe_q;
    wr_en   = 1'b0;

    if (!sel) begin
      phase_d = PH_CMD;
      cnt_d   = '0;
      oe_d    = 1'b0;
      sdo_d   = 1'b0;
    end else begin
      if (sclk_rise) begin
        cnt_d = last_bit ? '0 : cnt_q + 1'b1;
        if (phase_q != PH_READ) shf_d = byte_in[DATA_W-2:0];
      end
      if (byte_done) begin
        unique case (phase_q)
          PH_CMD: begin
            addr_d = byte_in[DATA_W-1:1];
            if (byte_in[0]) begin
              phase_d = PH_READ;
              oe_d    = 1'b1;
              sdo_d   = rd_data[DATA_W-1];
            end else begin
              phase_d = PH_WRITE;
            end
          end
          PH_WRITE: begin
            wr_en  = 1'b1;
            addr_d = addr_nxt;
          end
          default: addr_d = addr_nxt;
        endcase
      end else if (sclk_fall && phase_q == PH_READ) begin
        sdo_d = rd_data[bit_idx];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      shf_q   <= '0;
      addr_q  <= '0;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      shf_q   <= shf_d;
      addr_q  <= addr_d;
      sdo_q   <= sdo_d;
      oe_q    <= oe_d;
    end
  end

  assign wr_data = byte_in;
  assign addr    = addr_q;
  assign phase   = phase_q;
  assign sdo     = sdo_q;
  assign sdo_en  = oe_q;
endmodule

// File: rtl/spi_rb_regs.sv
module spi_rb_regs #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 12,
  localparam int ADDR_W  = DATA_W - 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] val_q, val_d;
    logic              hit;

    always_comb begin
      hit   = wr_en && (wr_addr == ADDR_W'(g));
      val_d = hit ? wr_data : val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign regs_flat[g*DATA_W +: DATA_W] = val_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = regs_flat[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
  import spi_rb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_REGS    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       sclk,
  input  logic                       sdi,
  output logic                       sdo,
  output logic                       sdo_en,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  localparam int ADDR_W = DATA_W - 1;

  logic              sel, sclk_rise, sclk_fall, sdi_s;
  logic [ADDR_W-1:0] rd_addr, addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en, byte_done;
  phase_e            phase;

  spi_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sel(sel), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdi_s(sdi_s)
  );

  spi_rb_ctrl #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .sdi_s(sdi_s), .rd_data(rd_data),
    .rd_addr(rd_addr), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .byte_done(byte_done), .phase(phase), .sdo(sdo), .sdo_en(sdo_en)
  );

  spi_rb_regs #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .regs_flat(regs_flat)
  );
endmodule

// File: rtl/spi_rb_checker.sv
module spi_rb_checker
  import spi_rb_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 12,
  localparam int ADDR_W  = DATA_W - 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sel,
  input logic                       sdo_en,
  input phase_e                     phase,
  input logic                       byte_done,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          addr,
  input logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  localparam int LAST = NUM_REGS - 1;

  // R7
  oe_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> (phase == PH_READ));

  // R7
  oe_off_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !sdo_en);

  // R6
  read_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && phase == PH_READ) |=> $stable(regs_flat));

  // R4
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase != PH_CMD) |=>
      (addr == (($past(addr) >= ADDR_W'(LAST)) ? '0 : $past(addr) + 1'b1)));

  // R9
  empty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr > ADDR_W'(LAST)) |=> $stable(regs_flat));

  // R8
  abort_to_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (phase == PH_CMD));
endmodule

bind spi_regbank_slave spi_rb_checker #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) i_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .sdo_en(sdo_en), .phase(phase),
  .byte_done(byte_done), .wr_en(wr_en), .addr(addr), .regs_flat(regs_flat)
);

// File: tb/test_spi_regbank_slave.sv
module test_spi_regbank_slave;
  localparam int NREG = 12;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdo_en;
  logic [NREG*8-1:0] regs_flat;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;
  logic [7:0] model [NREG];

  always #10 clk = ~clk;

  spi_regbank_slave i_spi_regbank_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .regs_flat(regs_flat)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic burst_start();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic burst_end();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  // nbits bits of tx, MSB first; rx captured just before each rising edge
  task automatic shift_bits(input logic [7:0] tx, input int nbits,
                            output logic [7:0] rx, output int oe_hi);
    rx = '0;
    oe_hi = 0;
    for (int i = 7; i > 7 - nbits; i--) begin
      sdi = tx[i];
      wait_clk(HALF);
      rx[i] = sdo;
      if (sdo_en) oe_hi++;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic check_bus(input string tag);
    for (int r = 0; r < NREG; r++)
      check(tag, {24'd0, regs_flat[r*8 +: 8]}, {24'd0, model[r]});
  endtask

  task automatic t_reset();
    for (int r = 0; r < NREG; r++) model[r] = 8'h00;
    check_bus("R1 reset value");
    check("R1 sdo_en after reset", {31'd0, sdo_en}, 32'd0);
  endtask

  task automatic t_single_write();
    logic [7:0] rx;
    int oe;
    burst_start();
    shift_bits({7'h03, 1'b0}, 8, rx, oe);
    check("R7 oe during command", oe, 0);
    shift_bits(8'hA5, 8, rx, oe);
    check("R7 oe during write", oe, 0);
    burst_end();
    model[3] = 8'hA5;
    check("R2 single write reg3", {24'd0, regs_flat[3*8 +: 8]}, 32'hA5);
    check_bus("R10 bus after single write");
  endtask

  task automatic t_burst_write();
    logic [7:0] rx;
    logic [7:0] vals [4];
    int oe;
    vals = '{8'h11, 8'h22, 8'h33, 8'h44};
    burst_start();
    shift_bits({7'h09, 1'b0}, 8, rx, oe);
    for (int b = 0; b < 4; b++) shift_bits(vals[b], 8, rx, oe);
    burst_end();
    model[9] = 8'h11; model[10] = 8'h22; model[11] = 8'h33; model[0] = 8'h44;
    check("R3 burst reg10", {24'd0, regs_flat[10*8 +: 8]}, 32'h22);
    check("R4 wrap write reg0", {24'd0, regs_flat[0 +: 8]}, 32'h44);
    check_bus("R3 bus after burst");
  endtask

  task automatic t_read_burst();
    logic [7:0] rx;
    logic [7:0] exp_v [4];
    int oe;
    exp_v = '{8'h11, 8'h22, 8'h33, 8'h44};
    burst_start();
    shift_bits({7'h09, 1'b1}, 8, rx, oe);
    for (int b = 0; b < 4; b++) begin
      shift_bits(8'h00, 8, rx, oe);
      check("R5 read burst data (R4 wrap)", {24'd0, rx}, {24'd0, exp_v[b]});
      check("R5 oe on every read bit", oe, 8);
    end
    burst_end();
    check("R7 oe off after release", {31'd0, sdo_en}, 32'd0);
  endtask

  task automatic t_read_ignores_sdi();
    logic [7:0] rx;
    int oe;
    burst_start();
    shift_bits({7'h03, 1'b1}, 8, rx, oe);
    shift_bits(8'hFF, 8, rx, oe);
    check("R6 read reg3 while sdi busy", {24'd0, rx}, 32'hA5);
    shift_bits(8'h5C, 8, rx, oe);
    check("R6 read reg4 while sdi busy", {24'd0, rx}, {24'd0, model[4]});
    burst_end();
    check_bus("R6 no register changed");
  endtask

  task automatic t_abort();
    logic [7:0] rx;
    int oe;
    burst_start();
    shift_bits({7'h05, 1'b0}, 8, rx, oe);
    shift_bits(8'hC3, 4, rx, oe);
    burst_end();
    check_bus("R8 partial byte discarded");
    burst_start();
    shift_bits({7'h05, 1'b0}, 8, rx, oe);
    shift_bits(8'h5A, 8, rx, oe);
    burst_end();
    model[5] = 8'h5A;
    check("R8 fresh burst after abort", {24'd0, regs_flat[5*8 +: 8]}, 32'h5A);
  endtask

  task automatic t_empty();
    logic [7:0] rx;
    int oe;
    burst_start();
    shift_bits({7'h20, 1'b0}, 8, rx, oe);
    shift_bits(8'h77, 8, rx, oe);
    shift_bits(8'h66, 8, rx, oe);
    burst_end();
    model[0] = 8'h66;
    check_bus("R9 empty write dropped, R4 wrap to 0");
    burst_start();
    shift_bits({7'h40, 1'b1}, 8, rx, oe);
    shift_bits(8'h00, 8, rx, oe);
    check("R9 empty read returns 0", {24'd0, rx}, 32'h00);
    shift_bits(8'h00, 8, rx, oe);
    check("R4 read wraps to reg0", {24'd0, rx}, 32'h66);
    burst_end();
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_single_write();
    t_burst_write();
    t_read_burst();
    t_read_ignores_sdi();
    t_abort();
    t_empty();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule